// File: doc/BRIEF.md
# Bit-Field Rotate-Mask-Merge Datapath

This block is the single-cycle execute stage of a small byte-wide controller that works on bit fields of one to eight bits. Each cycle it takes a decoded control word. It picks a source byte from the external I/O data input or from one of eight internal registers. It rotates the byte right so that the chosen field sits at bit 0 and clears every bit above the field. It then combines the field with register 0 in the ALU.

The ALU result is rotated left by the same amount and cut to the field width. It is then inserted into the untouched source byte, so bits outside the field keep their source values. The merged byte goes either to a register, which is written at the clock edge that closes the cycle, or to the I/O data output, where an output enable qualifies it for that single cycle. Instruction fetch and sequencing are not part of this block. A sequencer in front of it supplies the control word and the execute strobe.

Top module: `bitfield_dp`

## Requirements
- R1: When `src_bus_i` is 1 the source byte is `bus_din_i`. When it is 0 the source byte is register `src_sel_i`.
- R2: The field is the source rotated right by `rot_i` (0 to 7) with only its low L bits kept. L is `len_i` for codes 1 to 7, and code 0 means all 8 bits. A move of a bus source with code 0 to the bus returns the input byte unchanged for every rotate amount.
- R3: `op_i` selects the ALU function on the field F and register 0: 0 is move (F), 1 is add (F + R0, keeping the low 8 bits), 2 is AND (F & R0) and 3 is XOR (F ^ R0).
- R4: The low L bits of the ALU result are rotated left by `rot_i` and put in the output byte at those positions. Every other bit of the output byte equals the source byte.
- R5: An executed add loads `carry_o` at the clock edge with bit 8 of the 9-bit sum F + R0. Executed move, AND and XOR leave `carry_o` unchanged.
- R6: When `exec_i` is 1 and `dst_bus_i` is 0, register `dst_sel_i` takes the merged byte at the clock edge, and no other register changes.
- R7: `bus_oe_o` is 1 exactly in cycles with `exec_i` = 1 and `dst_bus_i` = 1. In those cycles `bus_dout_o` holds the merged byte and no register changes.
- R8: While `exec_i` is 0, no register and not `carry_o` changes, and `bus_oe_o` stays 0.
- R9: A clock edge with `rst_n` low clears all eight registers and `carry_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute the control word this cycle |
| src_bus_i | input | 1 | 1 selects the I/O data input as the source |
| src_sel_i | input | 3 | Source register index |
| rot_i | input | 3 | Right-rotate amount that brings the field to bit 0 |
| len_i | input | 3 | Field length, 0 meaning 8 |
| op_i | input | 2 | ALU function |
| dst_bus_i | input | 1 | 1 sends the result to the I/O output |
| dst_sel_i | input | 3 | Destination register index |
| bus_din_i | input | 8 | I/O data input |
| bus_dout_o | output | 8 | Merged byte |
| bus_oe_o | output | 1 | I/O output enable |
| carry_o | output | 1 | Carry flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and eight registers. With these values a complete sweep of all 64 rotate and length pairs fits in the run. The 3-bit codes therefore reach every field position, including fields that wrap past bit 7 and the length-0 (full byte) encoding. Because the register count is small, every register can be read back through a move to the bus after each phase of the run. This exposes stray writes, bus-destination cycles that wrongly write a register, idle cycles that change state, and the clearing done by reset.

// File: rtl/bfd_pkg.sv
`timescale 1ns/1ps
// Package: shared ALU function codes for the bit-field datapath.
// Assumes: a 2-bit opcode field in the decoded control word.
package bfd_pkg;
    typedef enum logic [1:0] {
        OP_MOV = 2'd0,
        OP_ADD = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } bfd_op_e;
endpackage

// File: rtl/bfd_rotator.sv
`timescale 1ns/1ps
// Module: bfd_rotator
// Rotates a W-bit word by a variable amount. A parameter picks the direction.
// Assumes: W is a power of two, so amt covers 0..W-1 exactly.
module bfd_rotator #(
    parameter int W        = 8,
    parameter bit ROT_LEFT = 1'b0,
    localparam int AW      = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;
    logic [2*W-1:0] moved;

    assign doubled = {din, din};

    generate
        if (ROT_LEFT) begin : g_left
            // Left rotate: the upper half of the shifted double word.
            always_comb begin
                moved = doubled << amt;
                dout  = moved[2*W-1:W];
            end
        end else begin : g_right
            // Right rotate: the lower half of the shifted double word.
            always_comb begin
                moved = doubled >> amt;
                dout  = moved[W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/bfd_mask_gen.sv
`timescale 1ns/1ps
// Module: bfd_mask_gen
// Builds a right-justified mask of L ones from a length code. Code 0 means W.
// Assumes: the code width is log2(W).
module bfd_mask_gen #(
    parameter int W   = 8,
    localparam int LW = $clog2(W)
) (
    input  logic [LW-1:0] len,
    output logic [W-1:0]  mask
);
    logic [W:0] one_at_len;

    // One-hot at bit L, then minus one gives L low ones.
    always_comb begin
        one_at_len = (W+1)'(1) << len;
        if (len == '0) mask = '1;
        else           mask = one_at_len[W-1:0] - W'(1);
    end
endmodule

// File: rtl/bfd_alu.sv
`timescale 1ns/1ps
// Module: bfd_alu
// Combines the isolated field with the accumulator register. Also gives the adder's carry out.
// Assumes: the carry out is only meaningful for the add function.
module bfd_alu
    import bfd_pkg::*;
#(
    parameter int W = 8
) (
    input  bfd_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] sum;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign cout = sum[W];

    // Function select.
    always_comb begin
        unique case (op)
            OP_MOV:  res = a;
            OP_ADD:  res = sum[W-1:0];
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/bfd_regfile.sv
`timescale 1ns/1ps
// Module: bfd_regfile
// Has N registers of W bits, one write port, one read port and a fixed tap on register 0.
// Assumes: synchronous active-low reset that clears every entry.
module bfd_regfile #(
    parameter int W   = 8,
    parameter int N   = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  r0
);
    logic [W-1:0] mem [N];

    // Storage update: clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
    assign r0    = mem[0];
endmodule

// File: rtl/bitfield_dp.sv
`timescale 1ns/1ps
// Module: bitfield_dp
// Single-cycle bit-field datapath. It selects the source, rotates it right and masks
// the field, applies the ALU, rotates the result back and merges it into the source byte.
// The result goes to a register at the clock edge or is driven onto the I/O output.
// Assumes: the control word is already decoded and held stable for the whole cycle.
module bitfield_dp
    import bfd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8,
    localparam int RW      = $clog2(DATA_W),
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic              src_bus_i,
    input  logic [AW-1:0]     src_sel_i,
    input  logic [RW-1:0]     rot_i,
    input  logic [RW-1:0]     len_i,
    input  logic [1:0]        op_i,
    input  logic              dst_bus_i,
    input  logic [AW-1:0]     dst_sel_i,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_oe_o,
    output logic              carry_o
);
    logic [DATA_W-1:0] reg_rd, reg_acc, src_byte;
    logic [DATA_W-1:0] src_rot, field_mask, field;
    logic [DATA_W-1:0] alu_res, res_rot, out_mask, merged;
    logic              alu_cout, reg_we, carry_q;
    bfd_op_e           op;

    assign op       = bfd_op_e'(op_i);
    assign src_byte = src_bus_i ? bus_din_i : reg_rd;
    assign reg_we   = exec_i && !dst_bus_i;

    bfd_regfile #(.W(DATA_W), .N(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (dst_sel_i),
        .wdata (merged),
        .raddr (src_sel_i),
        .rdata (reg_rd),
        .r0    (reg_acc)
    );

    bfd_rotator #(.W(DATA_W), .ROT_LEFT(1'b0)) u_rot_in (
        .din  (src_byte),
        .amt  (rot_i),
        .dout (src_rot)
    );

    bfd_mask_gen #(.W(DATA_W)) u_mask (
        .len  (len_i),
        .mask (field_mask)
    );

    assign field = src_rot & field_mask;

    bfd_alu #(.W(DATA_W)) u_alu (
        .op   (op),
        .a    (field),
        .b    (reg_acc),
        .res  (alu_res),
        .cout (alu_cout)
    );

    bfd_rotator #(.W(DATA_W), .ROT_LEFT(1'b1)) u_rot_res (
        .din  (alu_res),
        .amt  (rot_i),
        .dout (res_rot)
    );

    bfd_rotator #(.W(DATA_W), .ROT_LEFT(1'b1)) u_rot_mask (
        .din  (field_mask),
        .amt  (rot_i),
        .dout (out_mask)
    );

    assign merged = (res_rot & out_mask) | (src_byte & ~out_mask);

    // Carry flag: cleared on reset, loaded only by an executed add.
    always_ff @(posedge clk) begin
        if (!rst_n)                      carry_q <= 1'b0;
        else if (exec_i && op == OP_ADD) carry_q <= alu_cout;
    end

    assign carry_o    = carry_q;
    assign bus_dout_o = merged;
    assign bus_oe_o   = exec_i && dst_bus_i;
endmodule

// File: rtl/bfd_checker.sv
`timescale 1ns/1ps
// Module: bfd_checker
// Port-level properties of bitfield_dp. It is attached to the top with bind.
// Assumes: it sees the same clock and reset as the datapath.
module bfd_checker #(
    parameter int DATA_W = 8,
    parameter int AW     = 3,
    localparam int RW    = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic              src_bus_i,
    input logic [RW-1:0]     rot_i,
    input logic [RW-1:0]     len_i,
    input logic [1:0]        op_i,
    input logic              dst_bus_i,
    input logic [DATA_W-1:0] bus_din_i,
    input logic [DATA_W-1:0] bus_dout_o,
    input logic              bus_oe_o,
    input logic              carry_o
);
    // R7: the output enable is never high without an executed bus destination.
    a_r7_oe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (exec_i && dst_bus_i));

    // R8: an idle cycle never drives the bus.
    a_r8_idle_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |-> !bus_oe_o);

    // R2: a full-width move of a bus source returns the input for any rotate amount.
    a_r2_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && src_bus_i && op_i == 2'd0 && len_i == '0) |-> (bus_dout_o == bus_din_i));

    // R4: a one-bit field at bit 0 leaves the upper source bits untouched.
    a_r4_keep_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && src_bus_i && len_i == RW'(1) && rot_i == '0)
        |-> (bus_dout_o[DATA_W-1:1] == bus_din_i[DATA_W-1:1]));

    // R5: the carry only changes after an executed add.
    a_r5_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_i && op_i == 2'd1) |=> $stable(carry_o));

    // R9: a reset edge leaves the carry cleared.
    a_r9_reset_carry: assert property (@(posedge clk)
        !rst_n |=> (carry_o == 1'b0));
endmodule

bind bitfield_dp bfd_checker #(.DATA_W(DATA_W), .AW(AW)) u_bfd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec_i),
    .src_bus_i  (src_bus_i),
    .rot_i      (rot_i),
    .len_i      (len_i),
    .op_i       (op_i),
    .dst_bus_i  (dst_bus_i),
    .bus_din_i  (bus_din_i),
    .bus_dout_o (bus_dout_o),
    .bus_oe_o   (bus_oe_o),
    .carry_o    (carry_o)
);

// File: tb/bitfield_dp_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for bitfield_dp. The driver computes the expected results and queues
// them. The monitor compares them with the outputs in the middle of the low clock phase.
module bitfield_dp_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic       src_bus_i = 1'b0;
    logic [2:0] src_sel_i = '0;
    logic [2:0] rot_i = '0;
    logic [2:0] len_i = '0;
    logic [1:0] op_i = '0;
    logic       dst_bus_i = 1'b0;
    logic [2:0] dst_sel_i = '0;
    logic [7:0] bus_din_i = '0;
    logic [7:0] bus_dout_o;
    logic       bus_oe_o;
    logic       carry_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] dout;
        logic       oe;
        logic       carry;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    item_t      mon_it;
    logic [7:0] m_regs [8];
    logic       m_carry;

    always #10 clk = ~clk;

    bitfield_dp dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_i     (exec_i),
        .src_bus_i  (src_bus_i),
        .src_sel_i  (src_sel_i),
        .rot_i      (rot_i),
        .len_i      (len_i),
        .op_i       (op_i),
        .dst_bus_i  (dst_bus_i),
        .dst_sel_i  (dst_sel_i),
        .bus_din_i  (bus_din_i),
        .bus_dout_o (bus_dout_o),
        .bus_oe_o   (bus_oe_o),
        .carry_o    (carry_o)
    );

    // Monitor: pop one expected item per issued cycle and compare it mid low phase.
    always @(negedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            mon_it = sb_q.pop_front();
            checks++;
            if (bus_oe_o !== mon_it.oe) begin
                errors++;
                $display("FAIL %s oe actual %b expected %b", mon_it.tag, bus_oe_o, mon_it.oe);
            end
            if (mon_it.oe) begin
                checks++;
                if (bus_dout_o !== mon_it.dout) begin
                    errors++;
                    $display("FAIL %s dout actual %h expected %h", mon_it.tag, bus_dout_o, mon_it.dout);
                end
            end
            checks++;
            if (carry_o !== mon_it.carry) begin
                errors++;
                $display("FAIL %s carry actual %b expected %b", mon_it.tag, carry_o, mon_it.carry);
            end
        end
    end

    // Driver: apply one control word, queue its expected outcome and advance the model.
    task automatic issue(input bit sb, input int ss, input logic [7:0] din, input int r,
                         input int l, input int op, input bit db, input int ds,
                         input bit ex, input string tag);
        logic [7:0] src, fld, res, mrg;
        logic [8:0] sum;
        int         width;
        item_t      it;
        exec_i    = ex;
        src_bus_i = sb;
        src_sel_i = 3'(ss);
        bus_din_i = din;
        rot_i     = 3'(r);
        len_i     = 3'(l);
        op_i      = 2'(op);
        dst_bus_i = db;
        dst_sel_i = 3'(ds);
        src   = sb ? din : m_regs[ss];
        width = (l == 0) ? 8 : l;
        fld   = '0;
        for (int i = 0; i < width; i++) fld[i] = src[(i + r) % 8];
        sum = {1'b0, fld} + {1'b0, m_regs[0]};
        case (op)
            1:       res = sum[7:0];
            2:       res = fld & m_regs[0];
            3:       res = fld ^ m_regs[0];
            default: res = fld;
        endcase
        mrg = src;
        for (int i = 0; i < width; i++) mrg[(i + r) % 8] = res[i];
        it.dout  = mrg;
        it.oe    = ex && db;
        it.carry = m_carry;
        it.tag   = tag;
        sb_q.push_back(it);
        if (ex) begin
            if (!db) m_regs[ds] = mrg;
            if (op == 1) m_carry = sum[8];
        end
        @(negedge clk);
    endtask

    // Reset pulse of one clock edge, with the model cleared to match.
    task automatic pulse_reset();
        rst_n  = 1'b0;
        exec_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_carry = 1'b0;
    endtask

    // Read one register through a full-width move to the bus.
    task automatic readback(input int k, input string tag);
        issue(1'b0, k, 8'h00, 0, 0, 0, 1'b1, 0, 1'b1, tag);
    endtask

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_carry = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: every register and the carry read as zero after reset.
        for (int k = 0; k < 8; k++) readback(k, "R9");

        // R6: load each register from the bus; R1: read each back as a register source.
        for (int k = 0; k < 8; k++) issue(1'b1, 0, 8'(8'h3C ^ (k * 37)), 0, 0, 0, 1'b0, k, 1'b1, "R6");
        for (int k = 0; k < 8; k++) readback(k, "R1");

        // R2: sweep every rotate and length pair with a bus source moved to the bus.
        for (int r = 0; r < 8; r++)
            for (int l = 0; l < 8; l++)
                issue(1'b1, 0, 8'(8'hA5 ^ (r * 16 + l)), r, l, 0, 1'b0 ? 1'b0 : 1'b1, 0, 1'b1, "R2");

        // R3: mixed functions, sources and destinations, with the carry tracked (R5).
        for (int n = 0; n < 48; n++)
            issue((n % 5) == 0, n % 8, 8'(n * 29 + 7), (n * 3) % 8, (n * 5) % 8, n % 4,
                  (n % 3) == 0, (n * 7) % 8, 1'b1, "R3");
        // R4: merged register contents after the mix.
        for (int k = 0; k < 8; k++) readback(k, "R4");

        // R7: a register destination keeps the enable low; a bus destination raises it.
        issue(1'b1, 0, 8'h5A, 2, 3, 0, 1'b0, 5, 1'b1, "R7");
        issue(1'b1, 0, 8'h5A, 2, 3, 0, 1'b1, 5, 1'b1, "R7");
        readback(5, "R7");

        // R8: idle cycles write nothing and leave the carry alone.
        issue(1'b1, 0, 8'hFF, 0, 0, 0, 1'b0, 3, 1'b0, "R8");
        issue(1'b1, 0, 8'hFF, 0, 0, 1, 1'b0, 0, 1'b0, "R8");
        readback(3, "R8");
        readback(0, "R8");

        // R5: an add of 0xFF and 0x01 sets the carry, AND keeps it, and an add without carry clears it.
        issue(1'b1, 0, 8'hFF, 0, 0, 0, 1'b0, 0, 1'b1, "R5");
        issue(1'b1, 0, 8'h01, 0, 0, 1, 1'b1, 0, 1'b1, "R5");
        issue(1'b1, 0, 8'h0F, 0, 0, 2, 1'b1, 0, 1'b1, "R5");
        issue(1'b1, 0, 8'h00, 0, 0, 1, 1'b1, 0, 1'b1, "R5");
        issue(1'b1, 0, 8'h80, 7, 1, 1, 1'b1, 0, 1'b1, "R5");
        readback(0, "R5");

        // R9: a reset in the middle of the run clears the loaded registers again.
        for (int k = 0; k < 8; k++) issue(1'b1, 0, 8'(k + 1), 0, 0, 0, 1'b0, k, 1'b1, "R6");
        issue(1'b1, 0, 8'hFF, 0, 0, 1, 1'b0, 0, 1'b1, "R5");
        pulse_reset();
        for (int k = 0; k < 8; k++) readback(k, "R9");

        exec_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule